// File: doc/BRIEF.md
# 16-bit ALU with status flag register

This block is the arithmetic-logic unit of a small register machine. It takes two 16-bit two's complement operands and a 3-bit operation select, and it returns a 16-bit result in the same cycle. It supports six operations: add, subtract, bitwise NAND, and three single-position shifts. The shifts are left, logical right and arithmetic right.

Each operation also yields four status bits: zero, sign, carry and overflow. These bits go into a flag register on the clock edge where the write enable is high. The register keeps its value on every other edge. The surrounding datapath applies operands from its register file and raises the write enable when it commits the result. Conditional branches later read the stored flags.

Top module: `alu_flagged`

## Requirements
- R1: Operation code 0 (add) gives result A+B modulo 2^16. Carry is the carry-out of bit 15. Overflow is set when A and B have the same sign and the result sign differs from it.
- R2: Operation code 1 (subtract) gives result A-B modulo 2^16. Carry is the carry-out of A + ~B + 1. Overflow is set when the signs of A and B differ and the result sign differs from the sign of A.
- R3: Operation code 2 (NAND) gives the bitwise ~(A & B). Carry and overflow are 0.
- R4: Operation code 3 (shift left) gives {A[14:0],0} with carry = A[15] and overflow 0.
- R5: Operation code 4 (logical shift right) gives {0,A[15:1]} with carry = A[0] and overflow 0.
- R6: Operation code 5 (arithmetic shift right) gives {A[15],A[15:1]} with carry = A[0] and overflow 0.
- R7: Zero is 1 exactly when all 16 result bits are 0. Sign equals result bit 15.
- R8: The four flag outputs take the values of the current operation on a rising edge where flag_we is 1. On an edge where flag_we is 0 they keep their previous values.
- R9: A rising edge with rst_n low clears all four flags to 0.
- R10: Operation codes 6 and 7 give result 0 with carry 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 NAND, 3 shl, 4 shr, 5 sar) |
| opnd_a | input | 16 | First operand, also the shifted value |
| opnd_b | input | 16 | Second operand |
| flag_we | input | 1 | Capture the flags on this edge |
| alu_out | output | 16 | Combinational result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The result is combinational, so it is valid in the same cycle the operands are applied. The flags pass through one register and appear only after the next rising edge. The driver changes inputs at the falling edge and queues the expected result and flags. The monitor compares both 1 ns after the following rising edge, while the inputs are still held, so each check sees the result of the applied operands and the flags that edge has just written. Edges with the write enable low queue the previous flag values as the expected ones, which checks that the flags are held.

// File: rtl/alu_flagged_pkg.sv
// Package: shared width, operation codes and flag bundle for the ALU.
// Assumes operation codes are a 3-bit field decoded only by alu_flagged.
package alu_flagged_pkg;
    localparam int unsigned DW = 16;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_NAND = 3'd2,
        OP_SHL  = 3'd3,
        OP_SHR  = 3'd4,
        OP_SAR  = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor: one carry chain. For subtract it adds the inverted
// second operand with a carry-in of 1. Assumes two's complement operands.
module alu_addsub #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    // Select the true or inverted second operand and run the chain.
    always_comb begin
        b_eff       = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        ovf         = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_shift1.sv
// Single-position shifter: left, logical right and arithmetic right.
// The bit shifted out goes to the carry output. Assumes W >= 2.
module alu_shift1 #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] shl_q,
    output logic [W-1:0] shr_q,
    output logic [W-1:0] sar_q,
    output logic         shl_c,
    output logic         shr_c
);
    // Build all three shifted values and their shifted-out bits.
    always_comb begin
        shl_q = {a[W-2:0], 1'b0};
        shr_q = {1'b0, a[W-1:1]};
        sar_q = {a[W-1], a[W-1:1]};
        shl_c = a[W-1];
        shr_c = a[0];
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Flag register with synchronous active-low reset and a write enable.
// Assumes the flag inputs are stable at the rising edge.
module alu_flag_reg
    import alu_flagged_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);
    // Clear on reset, capture when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/alu_flagged.sv
// Top: 16-bit ALU with a combinational result and a registered flag set.
// Decodes the operation code, picks the result and carry/overflow from the
// arithmetic or shift unit, and derives zero and sign from the result.
// Assumes op_sel, opnd_a and opnd_b are stable around each rising edge.
module alu_flagged
    import alu_flagged_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_we,
    output logic [W-1:0] alu_out,
    output logic         flag_z,
    output logic         flag_s,
    output logic         flag_c,
    output logic         flag_v
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] as_sum, shl_q, shr_q, sar_q, res;
    logic         as_cout, as_ovf, shl_c, shr_c;
    logic         c_nx, v_nx;
    flags_t       f_nx, f_q;
    alu_op_e      op;

    assign op = alu_op_e'(op_sel);

    alu_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(op == OP_SUB),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu_shift1 #(.W(W)) u_shift (
        .a(opnd_a), .shl_q(shl_q), .shr_q(shr_q), .sar_q(sar_q),
        .shl_c(shl_c), .shr_c(shr_c)
    );

    // Select the result, carry and overflow for the operation code.
    always_comb begin
        res  = '0;
        c_nx = 1'b0;
        v_nx = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin res = as_sum; c_nx = as_cout; v_nx = as_ovf; end
            OP_NAND:        res = ~(opnd_a & opnd_b);
            OP_SHL:         begin res = shl_q; c_nx = shl_c; end
            OP_SHR:         begin res = shr_q; c_nx = shr_c; end
            OP_SAR:         begin res = sar_q; c_nx = shr_c; end
            default:        res = '0;
        endcase
    end

    // Bundle the next flag values from the selected result.
    always_comb begin
        f_nx.z = (res == '0);
        f_nx.s = res[MSB];
        f_nx.c = c_nx;
        f_nx.v = v_nx;
    end

    alu_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .d(f_nx), .q(f_q)
    );

    assign alu_out = res;
    assign flag_z  = f_q.z;
    assign flag_s  = f_q.s;
    assign flag_c  = f_q.c;
    assign flag_v  = f_q.v;

    assert_nand_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NAND) |-> (!c_nx && !v_nx));
    assert_shl_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHL) |-> (c_nx == opnd_a[MSB] && alu_out[0] == 1'b0));
    assert_shr_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHR) |-> (alu_out[MSB] == 1'b0 && c_nx == opnd_a[0]));
    assert_sar_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SAR) |-> (alu_out[MSB] == opnd_a[MSB]));
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flag_z == ($past(alu_out) == '0)));
    assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flag_s == $past(alu_out[MSB])));
    assert_spare_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd5) |-> (alu_out == '0 && !c_nx && !v_nx));
endmodule

// File: tb/alu_flagged_test.sv
// Scoreboard bench: the driver queues expected result and flags, and the
// monitor compares them 1 ns after each rising edge.
module alu_flagged_test;
    typedef struct packed {
        logic [15:0] r;
        logic        z, s, c, v;
        logic [7:0]  tag;
    } exp_t;

    logic        clk = 0, rst_n = 0, flag_we = 0;
    logic [2:0]  op_sel = 0;
    logic [15:0] opnd_a = 0, opnd_b = 0, alu_out;
    logic        flag_z, flag_s, flag_c, flag_v;
    int          n_run = 0, n_fail = 0;
    exp_t        sbq[$];
    logic [3:0]  held = 4'b0;
    logic        mon_on = 0;

    always #5 clk = ~clk;

    alu_flagged uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_we(flag_we), .alu_out(alu_out),
        .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic exp_t model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        exp_t e;
        logic [16:0] t;
        e = '0;
        case (op)
            3'd0: begin t = {1'b0,a} + {1'b0,b}; e.r = t[15:0]; e.c = t[16];
                        e.v = (a[15] == b[15]) && (e.r[15] != a[15]); end
            3'd1: begin t = {1'b0,a} + {1'b0,~b} + 17'd1; e.r = t[15:0]; e.c = t[16];
                        e.v = (a[15] != b[15]) && (e.r[15] != a[15]); end
            3'd2: e.r = ~(a & b);
            3'd3: begin e.r = {a[14:0],1'b0}; e.c = a[15]; end
            3'd4: begin e.r = {1'b0,a[15:1]}; e.c = a[0]; end
            3'd5: begin e.r = {a[15],a[15:1]}; e.c = a[0]; end
            default: e.r = 16'h0;
        endcase
        e.z = (e.r == 16'h0);
        e.s = e.r[15];
        return e;
    endfunction

    // Driver: apply at the falling edge and queue the expected item.
    task automatic drive(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic we, input logic [7:0] tag);
        exp_t e;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; flag_we = we;
        e = model(op, a, b);
        if (we) held = {e.z, e.s, e.c, e.v};
        else    {e.z, e.s, e.c, e.v} = held;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: pop and compare 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (mon_on && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_run++;
            if (alu_out !== e.r || {flag_z,flag_s,flag_c,flag_v} !== {e.z,e.s,e.c,e.v}) begin
                n_fail++;
                $display("FAIL R%0d: got r=%h zscv=%b expected r=%h zscv=%b", e.tag,
                         alu_out, {flag_z,flag_s,flag_c,flag_v}, e.r, {e.z,e.s,e.c,e.v});
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R9: flags cleared by reset
                flag_we = 1; op_sel = 3'd1; opnd_a = 16'h0000; opnd_b = 16'h0001;
                @(posedge clk); #1;
                n_run++;
                if ({flag_z,flag_s,flag_c,flag_v} !== 4'b0000) begin
                    n_fail++;
                    $display("FAIL R9: got zscv=%b expected 0000", {flag_z,flag_s,flag_c,flag_v});
                end
                @(negedge clk); rst_n = 1; mon_on = 1;
                drive(3'd0, 16'h0001, 16'h0001, 1, 1);   // R1 plain add
                drive(3'd0, 16'h7FFF, 16'h0001, 1, 1);   // R1 overflow
                drive(3'd0, 16'hFFFF, 16'h0001, 1, 7);   // R7 zero with carry
                drive(3'd0, 16'h8000, 16'h8000, 1, 1);   // R1 negative overflow
                drive(3'd1, 16'h0005, 16'h0003, 1, 2);   // R2 no borrow
                drive(3'd1, 16'h0003, 16'h0005, 1, 2);   // R2 borrow, sign
                drive(3'd1, 16'h8000, 16'h0001, 1, 2);   // R2 overflow
                drive(3'd1, 16'h1234, 16'h1234, 1, 7);   // R7 zero by subtract
                drive(3'd2, 16'hFFFF, 16'hFFFF, 1, 3);   // R3 zero result
                drive(3'd2, 16'h00FF, 16'h0F0F, 1, 3);   // R3 mixed
                drive(3'd3, 16'h8001, 16'h0000, 1, 4);   // R4 carry out
                drive(3'd3, 16'h4000, 16'h0000, 1, 4);   // R4 into sign
                drive(3'd4, 16'h8001, 16'h0000, 1, 5);   // R5
                drive(3'd4, 16'h0002, 16'h0000, 1, 5);   // R5 no carry
                drive(3'd5, 16'h8001, 16'h0000, 1, 6);   // R6 negative
                drive(3'd5, 16'h4000, 16'h0000, 1, 6);   // R6 positive
                drive(3'd0, 16'h7FFF, 16'h0001, 0, 8);   // R8 hold
                drive(3'd3, 16'h8000, 16'h0000, 0, 8);   // R8 hold
                drive(3'd6, 16'hFFFF, 16'hFFFF, 1, 10);  // R10
                drive(3'd7, 16'h1234, 16'h5678, 1, 10);  // R10
                drive(3'd0, 16'hFFFF, 16'hFFFF, 1, 1);   // R1 carry no overflow
                @(negedge clk); flag_we = 0;
                repeat (3) @(negedge clk);
            end
            begin
                repeat (2000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL R8: watchdog expired, got hang expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule